// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This block moves a complete execution context between the register file and a memory-resident task record. A request names a selector and says whether that selector is a task gate or a direct record descriptor. It also says whether the switch is a far jump, a far call or an interrupt return. The engine finds both records through a combinational descriptor-lookup stub. It writes the outgoing task's dynamic state to memory and, on a call, writes the back-link. It then reads the incoming record into the register file and commits the new task register, translation base, I/O map base and trap flag together.

Each task record is 23 words of 32 bits at fixed offsets:
- 0: link selector.
- 1..3: stack pointers.
- 4: translation base.
- 5: instruction pointer.
- 6: flags.
- 7..14: general registers.
- 15..20: segment registers.
- 21: local table selector.
- 22: bits 31:16 hold the I/O map base and bit 0 holds the trap bit.

Register-file slot n holds the item at record offset n. The request port and the memory port are valid/ready. The request holds its fields until it is accepted. A memory access holds address, direction and data stable until `mem_ready` is seen. Read data is taken in the handshake cycle. A task's busy flag is indexed by selector bits [5:3].

Top module: `tsw_seq`

## Requirements
- R1: Out of reset, `task_reg` equals the INIT_TR parameter (default 16'h0008) and that task is marked busy. `ptb`, `iomap_base`, `trap_pend`, `done` and `fault` are 0, and `req_ready` is 1.
- R2: A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while idle, so it is low from the cycle after acceptance until the switch ends. The request kind is encoded 0 = jump, 1 = call, 2 = return; code 3 acts as a jump.
- R3: When `req_gate` is 1, the target is the selector that the stub returns on `lk_gate_sel` for `req_sel`. When `req_gate` is 0, the target is `req_sel` itself.
- R4: A successful switch writes the outgoing record at offsets 5 to 20, taken from the matching register slots, one word per handshake, in ascending address order. Offsets 1 to 4, 21 and 22 are never written.
- R5: A call also writes the outgoing selector, zero-extended, into offset 0 of the incoming record. A jump or a return leaves every link word unchanged.
- R6: The load reads the incoming record at offsets 1 to 22 in ascending order. It writes slots 1 to 3 and 5 to 21 of the register file with the words read.
- R7: `ptb` takes offset 4 of the incoming record. `iomap_base` takes bits 31:16 of offset 22, and `trap_pend` takes bit 0 of offset 22. All three change together with `task_reg`.
- R8: At the end of a switch `task_reg` takes the target selector. `done` is high for exactly the one cycle after that update.
- R9: On a return, the target selector is bits 15:0 of offset 0 of the current task's record.
- R10: A call to a task already marked busy, or a return to a task not marked busy, raises `fault` for one cycle. It does no memory write and no register-file write, and `task_reg`, `ptb`, `iomap_base` and `trap_pend` keep their values.
- R11: Busy flags change only when a switch completes. A jump clears the outgoing flag and sets the target flag. A call sets the target flag and keeps the outgoing one. A return clears the outgoing flag.
- R12: Once `mem_valid` is high, it stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until a cycle with `mem_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Switch request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_kind | input | 2 | 0 jump, 1 call, 2 return |
| req_gate | input | 1 | Selector names a task gate |
| req_sel | input | SW | Requested selector |
| lk_sel | output | SW | Selector presented to lookup stub |
| lk_base | input | AW | Record base word address for `lk_sel` |
| lk_gate_sel | input | SW | Selector carried by the gate at `lk_sel` |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in handshake cycle |
| rf_idx | output | 5 | Register slot (equals record offset) |
| rf_rdata | input | DW | Combinational read of slot `rf_idx` |
| rf_we | output | 1 | Write slot `rf_idx` at clock edge |
| rf_wdata | output | DW | Register write data |
| task_reg | output | SW | Current task selector |
| ptb | output | DW | Current translation base |
| iomap_base | output | 16 | Current I/O map base |
| trap_pend | output | 1 | Incoming task had trap bit set |
| done | output | 1 | Switch completed (one cycle) |
| fault | output | 1 | Switch refused (one cycle) |

## Verification
The assertions assume that the memory answers every access eventually. They assume that `mem_rdata` and `rf_rdata` settle within the cycle. They also assume that requests arrive only while `req_ready` is high, because the engine ignores `req_valid` at other times. The bench meets these assumptions: it models memory and the register file as arrays with combinational reads, and it issues a request only when the engine is idle. It varies `mem_ready` through several stall patterns so that back-pressure lands on every save and load word.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int unsigned OFSW = 5;
  localparam logic [OFSW-1:0] W_LINK    = 5'd0;
  localparam logic [OFSW-1:0] W_STK0    = 5'd1;
  localparam logic [OFSW-1:0] W_PTB     = 5'd4;
  localparam logic [OFSW-1:0] W_EIP     = 5'd5;
  localparam logic [OFSW-1:0] W_DYN_END = 5'd20;
  localparam logic [OFSW-1:0] W_CFG     = 5'd22;

  typedef enum logic [1:0] {
    K_JMP  = 2'd0,
    K_CALL = 2'd1,
    K_RET  = 2'd2
  } sw_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CUR, S_LINKRD, S_GATE, S_TGT,
    S_SAVE, S_LINKWR, S_LOAD, S_COMMIT, S_DONE, S_FAULT
  } sw_state_e;
endpackage

// File: rtl/tsw_walk.sv
module tsw_walk #(
  parameter int unsigned OFSW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [OFSW-1:0] load_val,
  input  logic            adv,
  output logic [OFSW-1:0] ofs
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ofs <= '0;
    else if (load) ofs <= load_val;
    else if (adv)  ofs <= ofs + 1'b1;
  end
endmodule

// File: rtl/tsw_busy.sv
module tsw_busy #(
  parameter int unsigned NTASK    = 8,
  parameter int unsigned IDXW     = 3,
  parameter int unsigned INIT_IDX = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] q_idx,
  output logic            q_busy,
  input  logic            clr_en,
  input  logic [IDXW-1:0] clr_idx,
  input  logic            set_en,
  input  logic [IDXW-1:0] set_idx
);
  logic [NTASK-1:0] flag;

  for (genvar i = 0; i < NTASK; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        flag[i] <= (i == INIT_IDX);
      else if (set_en && set_idx == IDXW'(i))
        flag[i] <= 1'b1;
      else if (clr_en && clr_idx == IDXW'(i))
        flag[i] <= 1'b0;
    end
  end

  assign q_busy = flag[q_idx];
endmodule

// File: rtl/tsw_ctx.sv
module tsw_ctx #(
  parameter int unsigned DW      = 32,
  parameter int unsigned SW      = 16,
  parameter logic [SW-1:0] INIT_TR = 16'h0008
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_ptb,
  input  logic          cap_cfg,
  input  logic [DW-1:0] din,
  input  logic          commit,
  input  logic [SW-1:0] new_tr,
  output logic [SW-1:0] tr,
  output logic [DW-1:0] ptb,
  output logic [15:0]   iomap,
  output logic          trap
);
  logic [DW-1:0] ptb_s;
  logic [15:0]   io_s;
  logic          trap_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptb_s  <= '0;
      io_s   <= '0;
      trap_s <= 1'b0;
    end else begin
      if (cap_ptb) ptb_s <= din;
      if (cap_cfg) begin
        io_s   <= din[31:16];
        trap_s <= din[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tr    <= INIT_TR;
      ptb   <= '0;
      iomap <= '0;
      trap  <= 1'b0;
    end else if (commit) begin
      tr    <= new_tr;
      ptb   <= ptb_s;
      iomap <= io_s;
      trap  <= trap_s;
    end
  end
endmodule

// File: rtl/tsw_seq.sv
module tsw_seq
  import tsw_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 32,
  parameter int unsigned SW      = 16,
  parameter int unsigned NTASK   = 8,
  parameter logic [SW-1:0] INIT_TR = 16'h0008
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic            req_gate,
  input  logic [SW-1:0]   req_sel,
  output logic [SW-1:0]   lk_sel,
  input  logic [AW-1:0]   lk_base,
  input  logic [SW-1:0]   lk_gate_sel,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [OFSW-1:0] rf_idx,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [DW-1:0]   rf_wdata,
  output logic [SW-1:0]   task_reg,
  output logic [DW-1:0]   ptb,
  output logic [15:0]     iomap_base,
  output logic            trap_pend,
  output logic            done,
  output logic            fault
);
  localparam int unsigned IDXW     = $clog2(NTASK);
  localparam int unsigned INIT_IDX = int'(INIT_TR[3 +: IDXW]);

  sw_state_e     st, st_n;
  sw_kind_e      kind_q;
  logic          gate_q;
  logic [SW-1:0] sel_q, tgt_q;
  logic [AW-1:0] cur_base_q, tgt_base_q;

  logic            hs;
  logic            walk_ld, walk_adv;
  logic [OFSW-1:0] walk_val, ofs;
  logic            tgt_busy, refuse, commit;
  logic            is_call, is_ret;

  assign hs      = mem_valid && mem_ready;
  assign is_call = (kind_q == K_CALL);
  assign is_ret  = (kind_q == K_RET);
  assign refuse  = (is_call && tgt_busy) || (is_ret && !tgt_busy);

  tsw_walk #(.OFSW(OFSW)) walk_i (
    .clk(clk), .rst_n(rst_n), .load(walk_ld), .load_val(walk_val),
    .adv(walk_adv), .ofs(ofs)
  );

  tsw_busy #(.NTASK(NTASK), .IDXW(IDXW), .INIT_IDX(INIT_IDX)) busy_i (
    .clk(clk), .rst_n(rst_n),
    .q_idx(tgt_q[3 +: IDXW]), .q_busy(tgt_busy),
    .clr_en(commit && !is_call), .clr_idx(task_reg[3 +: IDXW]),
    .set_en(commit && !is_ret),  .set_idx(tgt_q[3 +: IDXW])
  );

  tsw_ctx #(.DW(DW), .SW(SW), .INIT_TR(INIT_TR)) ctx_i (
    .clk(clk), .rst_n(rst_n),
    .cap_ptb(st == S_LOAD && hs && ofs == W_PTB),
    .cap_cfg(st == S_LOAD && hs && ofs == W_CFG),
    .din(mem_rdata), .commit(commit), .new_tr(tgt_q),
    .tr(task_reg), .ptb(ptb), .iomap(iomap_base), .trap(trap_pend)
  );

  always_comb begin
    st_n      = st;
    req_ready = 1'b0;
    lk_sel    = task_reg;
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_base_q + AW'(ofs);
    mem_wdata = rf_rdata;
    rf_idx    = ofs;
    rf_we     = 1'b0;
    rf_wdata  = mem_rdata;
    walk_ld   = 1'b0;
    walk_val  = W_EIP;
    walk_adv  = 1'b0;
    commit    = 1'b0;
    done      = 1'b0;
    fault     = 1'b0;
    unique case (st)
      S_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) st_n = S_CUR;
      end
      S_CUR: begin
        lk_sel = task_reg;
        if (is_ret)      st_n = S_LINKRD;
        else if (gate_q) st_n = S_GATE;
        else             st_n = S_TGT;
      end
      S_LINKRD: begin
        mem_valid = 1'b1;
        mem_addr  = cur_base_q + AW'(W_LINK);
        if (hs) st_n = S_TGT;
      end
      S_GATE: begin
        lk_sel = sel_q;
        st_n   = S_TGT;
      end
      S_TGT: begin
        lk_sel   = tgt_q;
        walk_ld  = 1'b1;
        walk_val = W_EIP;
        st_n     = refuse ? S_FAULT : S_SAVE;
      end
      S_SAVE: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_base_q + AW'(ofs);
        mem_wdata = rf_rdata;
        if (hs) begin
          if (ofs == W_DYN_END) begin
            walk_ld  = 1'b1;
            walk_val = W_STK0;
            st_n     = is_call ? S_LINKWR : S_LOAD;
          end else begin
            walk_adv = 1'b1;
          end
        end
      end
      S_LINKWR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = tgt_base_q + AW'(W_LINK);
        mem_wdata = {{(DW-SW){1'b0}}, task_reg};
        if (hs) st_n = S_LOAD;
      end
      S_LOAD: begin
        mem_valid = 1'b1;
        mem_addr  = tgt_base_q + AW'(ofs);
        rf_we     = hs && (ofs != W_PTB) && (ofs != W_CFG);
        if (hs) begin
          if (ofs == W_CFG) st_n = S_COMMIT;
          else              walk_adv = 1'b1;
        end
      end
      S_COMMIT: begin
        commit = 1'b1;
        st_n   = S_DONE;
      end
      S_DONE: begin
        done = 1'b1;
        st_n = S_IDLE;
      end
      S_FAULT: begin
        fault = 1'b1;
        st_n  = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      kind_q     <= K_JMP;
      gate_q     <= 1'b0;
      sel_q      <= '0;
      tgt_q      <= '0;
      cur_base_q <= '0;
      tgt_base_q <= '0;
    end else begin
      st <= st_n;
      unique case (st)
        S_IDLE: if (req_valid) begin
          kind_q <= (req_kind == 2'd1) ? K_CALL :
                    (req_kind == 2'd2) ? K_RET  : K_JMP;
          gate_q <= req_gate;
          sel_q  <= req_sel;
        end
        S_CUR: begin
          cur_base_q <= lk_base;
          tgt_q      <= sel_q;
        end
        S_LINKRD: if (hs) tgt_q <= mem_rdata[SW-1:0];
        S_GATE:   tgt_q <= lk_gate_sel;
        S_TGT:    tgt_base_q <= lk_base;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tsw_seq_chk.sv
module tsw_seq_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          rf_we,
  input logic [SW-1:0] task_reg,
  input logic [DW-1:0] ptb,
  input logic          done,
  input logic          fault
);
  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  tr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (task_reg != $past(task_reg)) |-> done);

  // R7
  ptb_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptb != $past(ptb)) |-> done);

  // R10
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!done && !mem_valid && !rf_we));

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_valid && !done && !fault));

  // R6
  rf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_valid && mem_ready && !mem_we));
endmodule

bind tsw_seq tsw_seq_chk #(.AW(AW), .DW(DW), .SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rf_we(rf_we),
  .task_reg(task_reg), .ptb(ptb), .done(done), .fault(fault)
);

// File: tb/tsw_seq_tb_top.sv
module tsw_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic        req_gate = 1'b0;
  logic [15:0] req_sel = '0;
  logic [15:0] lk_sel, lk_gate_sel;
  logic [15:0] lk_base;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b1;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [4:0]  rf_idx;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic [15:0] task_reg;
  logic [31:0] ptb;
  logic [15:0] iomap_base;
  logic        trap_pend, done, fault;

  always #2.5 clk = ~clk;

  logic [31:0] mem  [0:255];
  logic [31:0] mexp [0:255];
  logic [31:0] rf   [0:31];
  logic [31:0] rfexp[0:31];
  logic [7:0]  ebusy;
  logic [15:0] etr;
  logic [31:0] eptb;
  logic [15:0] eio;
  logic        etrap;

  int nvec = 0, nbad = 0, cyc = 0, stall_mode = 0;
  int wr_cnt = 0, order_bad = 0, n_call_flt = 0, n_ret_flt = 0;
  logic [15:0] last_wr;
  bit have_last = 0;

  function automatic logic [15:0] gate_tgt(input logic [15:0] s);
    return {10'd0, 3'(s[5:3] + 3'd3), 3'b000};
  endfunction

  assign lk_base     = {8'd0, lk_sel[5:3], 5'd0};
  assign lk_gate_sel = gate_tgt(lk_sel);
  assign mem_rdata   = mem[mem_addr[7:0]];
  assign rf_rdata    = rf[rf_idx];

  tsw_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_gate(req_gate), .req_sel(req_sel),
    .lk_sel(lk_sel), .lk_base(lk_base), .lk_gate_sel(lk_gate_sel),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_idx(rf_idx), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .task_reg(task_reg), .ptb(ptb), .iomap_base(iomap_base),
    .trap_pend(trap_pend), .done(done), .fault(fault)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_valid && mem_ready && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt = wr_cnt + 1;
      if (have_last && mem_addr[15:5] == last_wr[15:5] && mem_addr <= last_wr)
        order_bad = order_bad + 1;
      last_wr   = mem_addr;
      have_last = 1;
    end
    if (rf_we) rf[rf_idx] <= rf_wdata;
  end

  always @(negedge clk) begin
    case (stall_mode)
      0: mem_ready = 1'b1;
      1: mem_ready = (cyc % 3) != 0;
      2: mem_ready = (cyc % 4) == 1;
      default: mem_ready = (cyc % 5) > 1;
    endcase
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_switch(input logic [1:0] k, input logic g, input logic [15:0] s);
    logic [15:0] tgt;
    int cb, tb, wexp, lim, mism;
    bit flt, got_done, got_fault;
    cb  = int'(etr[5:3]) * 32;
    tgt = g ? gate_tgt(s) : s;
    if (k == 2'd2) tgt = mexp[cb][15:0];
    tb  = int'(tgt[5:3]) * 32;
    flt = (k == 2'd1 && ebusy[tgt[5:3]]) || (k == 2'd2 && !ebusy[tgt[5:3]]);
    if (!flt) begin
      for (int w = 5; w <= 20; w++) mexp[cb + w] = rfexp[w];
      if (k == 2'd1) mexp[tb] = {16'd0, etr};
      for (int w = 1; w <= 21; w++) if (w != 4) rfexp[w] = mexp[tb + w];
      eptb  = mexp[tb + 4];
      eio   = mexp[tb + 22][31:16];
      etrap = mexp[tb + 22][0];
      if (k != 2'd1) ebusy[etr[5:3]] = 1'b0;
      if (k != 2'd2) ebusy[tgt[5:3]] = 1'b1;
      etr  = tgt;
      wexp = (k == 2'd1) ? 17 : 16;
    end else begin
      wexp = 0;
      if (k == 2'd1) n_call_flt++; else n_ret_flt++;
    end

    @(negedge clk);
    wr_cnt = 0; have_last = 0; order_bad = 0;
    req_valid = 1'b1; req_kind = k; req_gate = g; req_sel = s;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "ready low after accept", 32'(req_ready), 32'd0);
    got_done = 0; got_fault = 0; lim = 0;
    while (!done && !fault && lim < 400) begin
      @(negedge clk);
      lim++;
    end
    got_done = done; got_fault = fault;
    chk(got_done == !flt && got_fault == flt, "R11", "done/fault outcome",
        {30'd0, got_fault, got_done}, {30'd0, flt, !flt});
    @(negedge clk);
    chk(!done && !fault, "R8", "single-cycle end pulse",
        {30'd0, fault, done}, 32'd0);
    chk(task_reg == etr, (k == 2'd2) ? "R9" : (g ? "R3" : "R8"), "task_reg",
        32'(task_reg), 32'(etr));
    chk(wr_cnt == wexp, flt ? "R10" : "R4", "memory write count",
        32'(wr_cnt), 32'(wexp));
    chk(order_bad == 0, "R4", "ascending save order", 32'(order_bad), 32'd0);
    mism = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== mexp[a]) mism++;
    chk(mism == 0, flt ? "R10" : "R5", "memory image mismatches", 32'(mism), 32'd0);
    mism = 0;
    for (int r = 1; r <= 21; r++) if (rf[r] !== rfexp[r]) mism++;
    chk(mism == 0, "R6", "register file mismatches", 32'(mism), 32'd0);
    chk(ptb == eptb, "R7", "ptb", ptb, eptb);
    chk(iomap_base == eio && trap_pend == etrap, "R7", "iomap/trap",
        {iomap_base, 15'd0, trap_pend}, {eio, 15'd0, etrap});
  endtask

  initial begin
    for (int t = 0; t < 8; t++)
      for (int w = 0; w < 32; w++) begin
        logic [31:0] v;
        if (w == 0)       v = {16'd0, 10'd0, 3'(t + 1), 3'b000};
        else if (w == 22) v = {16'h0100 + 16'(t), 15'd0, 1'(t % 2)};
        else              v = {8'(t), 8'(w), 16'(t * w + 5)};
        mem[t * 32 + w]  = v;
        mexp[t * 32 + w] = v;
      end
    for (int r = 0; r < 32; r++) begin
      rf[r]    = 32'hA000_0000 + 32'(r * 32'h111);
      rfexp[r] = rf[r];
    end
    ebusy = 8'b0000_0010; etr = 16'h0008; eptb = '0; eio = '0; etrap = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(task_reg == 16'h0008 && ptb == 0 && iomap_base == 0 && !trap_pend,
        "R1", "reset context", {task_reg, iomap_base}, 32'h0008_0000);
    chk(req_ready && !done && !fault, "R1", "reset handshake",
        {29'd0, req_ready, done, fault}, 32'd4);

    for (int t = 2; t < 8; t++) begin
      stall_mode = t % 4;
      do_switch(2'd0, 1'b0, 16'(t << 3));
    end
    do_switch(2'd3, 1'b0, 16'h0008);
    for (int gs = 0; gs < 8; gs++) begin
      stall_mode = gs % 4;
      do_switch(2'd0, 1'b1, 16'(gs << 3));
    end
    stall_mode = 1;
    do_switch(2'd1, 1'b0, 16'(((int'(etr[5:3]) + 1) % 8) << 3));
    do_switch(2'd1, 1'b1, 16'(((int'(etr[5:3]) + 4) % 8) << 3));
    stall_mode = 2;
    do_switch(2'd1, 1'b0, 16'(((int'(etr[5:3]) + 2) % 8) << 3));
    do_switch(2'd1, 1'b0, etr);
    stall_mode = 3;
    for (int i = 0; i < 5; i++) do_switch(2'd2, 1'b0, 16'd0);
    stall_mode = 0;
    do_switch(2'd0, 1'b0, 16'h0030);
    do_switch(2'd1, 1'b0, 16'h0010);
    do_switch(2'd2, 1'b0, 16'd0);
    do_switch(2'd2, 1'b0, 16'd0);
    chk(n_call_flt > 0, "R10", "call-to-busy fault seen", 32'(n_call_flt), 32'd1);
    chk(n_ret_flt > 0, "R10", "return-to-idle fault seen", 32'(n_ret_flt), 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    nbad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule